// File: doc/BRIEF.md
# Set/Clear Inter-Core Mailbox Bank

The block holds sixteen 32-bit mailbox words, four for each of four processor cores, for signalling between processors. Software raises bits in a mailbox through one address window and removes them through a second window. A write to the raise window ORs its data into the word. A write to the removal window clears every bit that is 1 in the write data. The removal window also serves reads of the current contents. Reads of the raise window return zero.

Each mailbox drives one pending flag, which stays high while any bit of its word is set. The sixteen flags go to a separate interrupt router that sits on the same register port. Accesses at offsets outside the two windows fall through to that router, so this block leaves them alone. Mailbox number n is core*4 + j, where j is the mailbox within the core. Flag bit n and the word at window base + 4*n both belong to mailbox n.

Top module: `mbx_bank`

## Requirements
- R1: A synchronous active-high reset clears all sixteen words to zero. All pending flags are low from the first cycle after reset.
- R2: A write to byte offset 0x80 + 4*n (n = 0..15) ORs `wr_data` into mailbox n at that clock edge. Bits that were already set stay set.
- R3: A write to byte offset 0xC0 + 4*n clears each bit of mailbox n whose position is 1 in `wr_data`, and leaves its other bits unchanged. A write of zero changes nothing.
- R4: A read (`rd_en` high) at offset 0xC0 + 4*n returns mailbox n on `rd_data` in the same cycle, and the contents do not change.
- R5: A read at any offset from 0x80 to 0xBF returns zero.
- R6: `pending[n]` is high exactly when mailbox n is non-zero. It follows a write from the cycle after that write's clock edge.
- R7: Writes to offsets outside 0x80..0xFF, and writes whose two low address bits are non-zero, change no mailbox. Reads at those offsets return zero.
- R8: A write to one mailbox changes no other mailbox and no other pending flag. Mailbox n = core*4 + j maps to `pending[n]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle `rd_en` is high |
| pending | output | 16 | Per-mailbox non-empty flag, bit n for mailbox n |

## Verification
The assertions check these properties on every cycle:
- After a raise-window write, every written bit is present in the targeted word.
- After a removal-window write, every cleared bit is absent.
- An unaddressed word holds its value.
- Reset empties every word.
- At most one mailbox is selected at a time.
- A raise-window read returns zero.

Other behaviour needs the bench's scenarios, which compare against a behavioural model every cycle:
- Exact OR and clear results on words that already hold data.
- The one-cycle lag of the flags.
- Accesses that are misaligned or outside both windows.
- Data that belongs to one core not reaching a neighbouring mailbox.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    parameter int NUM_CORES    = 4;
    parameter int BOX_PER_CORE = 4;
    parameter int DATA_W       = 32;
    parameter int ADDR_W       = 8;
    parameter int SET_BASE     = 'h80;
    parameter int CLR_BASE     = 'hC0;

    localparam int NUM_BOX  = NUM_CORES * BOX_PER_CORE;
    localparam int IDX_W    = $clog2(NUM_BOX);
    localparam int STRIDE   = DATA_W / 8;
    localparam int LSB_W    = $clog2(STRIDE);
    localparam int WIN_SPAN = NUM_BOX * STRIDE;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;

    typedef struct packed {
        win_e             win;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t        d;
        int unsigned u;
        u     = int'(a);
        d.win = WIN_NONE;
        d.idx = '0;
        if (a[LSB_W-1:0] == '0) begin
            if (u >= SET_BASE && u < SET_BASE + WIN_SPAN) begin
                d.win = WIN_SET;
                d.idx = IDX_W'((u - SET_BASE) >> LSB_W);
            end else if (u >= CLR_BASE && u < CLR_BASE + WIN_SPAN) begin
                d.win = WIN_CLR;
                d.idx = IDX_W'((u - CLR_BASE) >> LSB_W);
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [NUM_BOX-1:0] set_sel,
    output logic [NUM_BOX-1:0] clr_sel
);
    always_comb begin
        dec     = decode_addr(addr);
        set_sel = '0;
        clr_sel = '0;
        if (wr_en && dec.win == WIN_SET) set_sel[dec.idx] = 1'b1;
        if (wr_en && dec.win == WIN_CLR) clr_sel[dec.idx] = 1'b1;
    end

    // R8: a single write targets at most one mailbox
    always_comb begin
        a_r8_one_target: assert ($onehot0(set_sel | clr_sel));
    end
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] word,
    output logic              pending
);
    always_ff @(posedge clk) begin
        if (rst)         word <= '0;
        else if (set_en) word <= word | wr_data;
        else if (clr_en) word <= word & ~wr_data;
    end

    assign pending = |word;

    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (word == '0 && !pending));
    a_r2_set_bits_present: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((word & $past(wr_data)) == $past(wr_data)));
    a_r3_cleared_bits_absent: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((word & $past(wr_data)) == '0));
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(word));
endmodule

// File: rtl/mbx_readmux.sv
module mbx_readmux
    import mbx_pkg::*;
(
    input  logic              rd_en,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] words [NUM_BOX],
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (rd_en && dec.win == WIN_CLR) rd_data = words[dec.idx];
    end

    // R5: the raise window never returns data
    always_comb begin
        if (rd_en && dec.win == WIN_SET)
            a_r5_set_window_zero: assert (rd_data == '0);
    end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_BOX-1:0] pending
);
    dec_t               dec;
    logic [NUM_BOX-1:0] set_sel;
    logic [NUM_BOX-1:0] clr_sel;
    logic [DATA_W-1:0]  words [NUM_BOX];

    mbx_decode u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .dec     (dec),
        .set_sel (set_sel),
        .clr_sel (clr_sel)
    );

    for (genvar n = 0; n < NUM_BOX; n++) begin : g_box
        mbx_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_en  (set_sel[n]),
            .clr_en  (clr_sel[n]),
            .wr_data (wr_data),
            .word    (words[n]),
            .pending (pending[n])
        );
    end

    mbx_readmux u_rd (
        .rd_en   (rd_en),
        .dec     (dec),
        .words   (words),
        .rd_data (rd_data)
    );

    // R6: a raise with non-zero data leaves some flag high next cycle
    a_r6_flag_after_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && set_sel != '0 && wr_data != '0) |=> (pending != '0));
endmodule

// File: tb/tb_mbx_bank.sv
module tb_mbx_bank;
    import mbx_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_BOX-1:0] pending;

    bit [31:0] model [16];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    mbx_bank dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pending(pending)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R6/R8: flags compared to the model on every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [15:0] expf;
            for (int i = 0; i < 16; i++) expf[i] = (model[i] != 0);
            chk(pending == expf, "R6/R8 pending", {16'h0, pending}, {16'h0, expf});
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        for (int i = 0; i < 16; i++) model[i] = 0;
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1;
        if (a[1:0] == 2'b00 && a >= 8'h80 && a < 8'hC0)
            model[(a - 8'h80) >> 2] |= d;
        else if (a[1:0] == 2'b00 && a >= 8'hC0)
            model[(a - 8'hC0) >> 2] &= ~d;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2;
        if (a[1:0] == 2'b00 && a >= 8'hC0) exp = model[(a - 8'hC0) >> 2];
        else exp = 0;
        chk(rd_data === exp, tag, rd_data, exp);
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 16; i++) rd(8'(8'hC0 + 4 * i), tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 0;
        do_reset();
        rd_all("R1 reset contents");

        wr(8'h80, 32'h0000_00A5);
        rd(8'hC0, "R2 first set");
        wr(8'h80, 32'h0F00_0000);
        rd(8'hC0, "R2 OR keeps bits");
        rd(8'hC0, "R4 read does not clear");
        rd(8'hC4, "R8 neighbour untouched");

        wr(8'hC0, 32'h0000_0000);
        rd(8'hC0, "R3 clear with zero");
        wr(8'hC0, 32'h0000_0085);
        rd(8'hC0, "R3 partial clear");
        wr(8'hC0, 32'hFFFF_FFFF);
        rd(8'hC0, "R3 full clear");

        for (int i = 0; i < 16; i++)
            wr(8'(8'h80 + 4 * i), 32'h0101_0101 * (i + 1));
        rd_all("R8 per-mailbox data");

        rd(8'h80, "R5 set window read");
        rd(8'hBC, "R5 set window read top");
        rd(8'h94, "R5 set window read mid");

        wr(8'h7C, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'hC1, 32'hFFFF_FFFF);
        wr(8'h82, 32'h8000_0000);
        wr(8'h40, 32'hFFFF_FFFF);
        rd_all("R7 stray writes ignored");
        rd(8'h7C, "R7 stray read zero");
        rd(8'hC2, "R7 misaligned read zero");

        wr(8'hEC, 32'hFFFF_FFFF);
        rd(8'hEC, "R6 core2 box3 emptied");
        rd(8'hF0, "R8 core3 box0 kept");

        do_reset();
        rd_all("R1 reset after use");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule